// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter

This block turns parallel stereo sample pairs into a framed serial stream for an audio converter. A producer offers a left word and a right word together through a valid/ready handshake. The block takes one pair at the start of each frame and shifts it out, MSB first, on a single data line. A frame clock marks the left and right halves of the frame, and a bit clock times each bit slot.

When the block is clock master, it divides its own clock input (the master clock) down to the bit clock and the frame clock. When it is slave, it follows a bit clock and a frame clock driven by the converter, brings them into its clock domain and launches data on the selected edge. Static settings choose:

- the sample width;
- left or right alignment inside each half-frame;
- the one-slot data delay used by standard I2S framing;
- the polarity of each clock;
- the two divider ratios;
- whether the bit clock keeps running while the block is idle.

Settings are captured only while the block is disabled. If no pair is offered at a frame start, the block sends a silent frame and raises a sticky underrun flag.

Top module: `i2s_tx_serializer`

## Requirements
- R1: Sample width code 0 means 16 bits, 1 means 24 bits and 2 means 32 bits. The sample sits in the low bits of each input word, and the bits of a half-frame are sent most significant first.
- R2: With right alignment off, the sample MSB goes out in the first slot of its half-frame. Slots after the last sample bit carry 0. If the sample is wider than the half-frame, its low bits are cut off.
- R3: With right alignment on, the sample LSB goes out in the last slot of its half-frame. Earlier unused slots carry 0. If the sample is wider than the half-frame, its high bits are cut off.
- R4: With the delay bit set, the data stream lags the frame clock by exactly one slot, across half and frame boundaries. The first slot after enable carries 0. With the delay bit clear, there is no lag.
- R5: With frame polarity 0, `lrck_o` is low during the left half and high during the right half; polarity 1 inverts it. The data and frame clock change in the same cycle.
- R6: With bit-clock polarity 0, data and frame clock change on the falling edge of `bck_o`, and the bit clock idles high. Polarity 1 inverts the bit clock, so data launches on its rising edge.
- R7: In master mode each bit slot lasts 2 clock cycles (`cfg_mdiv_i`=0) or 4 (`cfg_mdiv_i`=1). A frame has 32, 64 or 128 slots for `cfg_fdiv_i`=0, 1 or 2, split equally between left and right.
- R8: In slave mode `bck_o` and `lrck_o` are held low. Data launches on the external bit clock edge chosen by the polarity setting. Halves follow the external frame clock, and the half size for right alignment comes from `cfg_fdiv_i`.
- R9: The block runs only while both `glb_en_i` and `ch_en_i` are high. Otherwise `smp_ready_o` stays low and `sd_o` is 0. Each enable restarts at left slot 0.
- R10: While disabled, the master bit clock stops at its idle level when `cfg_free_bck_i` is 0. When it is 1, the bit clock keeps toggling at the selected rate while the frame clock stays still.
- R11: `smp_ready_o` is high for one cycle at the start of each frame (left half, slot 0) while enabled. The pair is taken if `smp_valid_i` is high in that cycle.
- R12: If no valid pair is present at a frame start, both halves of that frame are 0 and `underrun_o` is set. The flag holds until an `underrun_clr_i` pulse. A new underrun in the same cycle as a clear wins.
- R13: Configuration inputs are captured only while the block is disabled. Changes made while it runs have no effect until the next disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| glb_en_i | input | 1 | Global enable |
| ch_en_i | input | 1 | Transmit channel enable |
| cfg_wlen_i | input | 2 | Sample width code |
| cfg_rjust_i | input | 1 | Right alignment in half-frame |
| cfg_dly_i | input | 1 | One-slot data delay |
| cfg_lr_pol_i | input | 1 | Frame clock polarity |
| cfg_bck_pol_i | input | 1 | Bit clock polarity |
| cfg_master_i | input | 1 | 1: drive clocks, 0: follow external clocks |
| cfg_free_bck_i | input | 1 | Keep bit clock running while idle |
| cfg_mdiv_i | input | 1 | Clock cycles per slot: 0→2, 1→4 |
| cfg_fdiv_i | input | 2 | Slots per frame: 0→32, 1→64, 2→128 |
| smp_valid_i | input | 1 | Sample pair valid |
| smp_ready_o | output | 1 | Sample pair taken this cycle |
| smp_left_i | input | SMP_W | Left sample |
| smp_right_i | input | SMP_W | Right sample |
| ext_bck_i | input | 1 | External bit clock (slave) |
| ext_lrck_i | input | 1 | External frame clock (slave) |
| bck_o | output | 1 | Bit clock (master) |
| lrck_o | output | 1 | Frame clock (master) |
| sd_o | output | 1 | Serial data |
| underrun_o | output | 1 | Sticky underrun flag |
| underrun_clr_i | input | 1 | Clear pulse for the underrun flag |

## Verification
A frame start that finds no valid pair sets the underrun flag, and a clear pulse can land in that same cycle. The bench enables the block with valid low, waits until the ready strobe shows at a falling clock edge, and raises the clear for exactly that cycle. It then expects the flag to read 1. A later clear alone, while valid pairs keep arriving, must bring it back to 0.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

  typedef struct packed {
    logic [1:0] wlen;
    logic       rjust;
    logic       dly;
    logic       lr_pol;
    logic       bck_pol;
    logic       master;
    logic       free_bck;
    logic       mdiv;
    logic [1:0] fdiv;
  } tx_cfg_t;

  localparam int unsigned SLOT_W = 7;
  localparam int unsigned BITS_W = 6;
  localparam int unsigned PH_W   = 3;

  function automatic logic [BITS_W-1:0] word_bits(input logic [1:0] code);
    case (code)
      2'd0:    return BITS_W'(16);
      2'd1:    return BITS_W'(24);
      default: return BITS_W'(32);
    endcase
  endfunction

  function automatic logic [SLOT_W-1:0] half_slots(input logic [1:0] code);
    case (code)
      2'd0:    return SLOT_W'(16);
      2'd1:    return SLOT_W'(32);
      default: return SLOT_W'(64);
    endcase
  endfunction

  function automatic logic [PH_W-1:0] slot_cycles(input logic code);
    return code ? PH_W'(4) : PH_W'(2);
  endfunction

endpackage

// File: rtl/i2s_tx_mclk_div.sv
module i2s_tx_mclk_div
  import i2s_tx_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            act_i,
  input  logic [PH_W-1:0] ratio_i,
  output logic            tick_o,
  output logic            bck_raw_o
);

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] half_ph;

  assign half_ph = ratio_i >> 1;
  assign tick_o  = act_i && (ph_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q      <= '0;
      bck_raw_o <= 1'b1;
    end else if (!run_i) begin
      ph_q      <= '0;
      bck_raw_o <= 1'b1;
    end else begin
      ph_q <= (ph_q >= ratio_i - PH_W'(1)) ? '0 : ph_q + PH_W'(1);
      // launch phase low, sample phase high
      if (ph_q == '0)          bck_raw_o <= 1'b0;
      else if (ph_q == half_ph) bck_raw_o <= 1'b1;
    end
  end

endmodule

// File: rtl/i2s_tx_ext_sync.sv
module i2s_tx_ext_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bck_i,
  input  logic lrck_i,
  input  logic bck_pol_i,
  input  logic lr_pol_i,
  output logic launch_o,
  output logic right_o
);

  localparam int unsigned DEPTH = STAGES + 1;

  logic [1:0] stg_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= 2'b01;
    else         stg_q[0] <= {lrck_i, bck_i};
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[k] <= 2'b01;
      else         stg_q[k] <= stg_q[k-1];
    end
  end

  logic raw_cur, raw_prv;
  assign raw_cur  = stg_q[STAGES-1][0] ^ bck_pol_i;
  assign raw_prv  = stg_q[STAGES][0]   ^ bck_pol_i;
  assign launch_o = raw_prv && !raw_cur;
  assign right_o  = stg_q[STAGES-1][1] ^ lr_pol_i;

endmodule

// File: rtl/i2s_tx_slot_ctr.sv
module i2s_tx_slot_ctr
  import i2s_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic              tick_i,
  input  logic              master_i,
  input  logic [SLOT_W-1:0] half_i,
  input  logic              ext_right_i,
  output logic [SLOT_W-1:0] cur_slot_o,
  output logic              cur_right_o,
  output logic              frame_start_o
);

  logic [SLOT_W-1:0] slot_q;
  logic              right_q;
  logic              started_q;

  always_comb begin
    if (master_i) begin
      cur_slot_o  = slot_q;
      cur_right_o = right_q;
    end else if (!started_q || ext_right_i != right_q) begin
      cur_slot_o  = '0;
      cur_right_o = ext_right_i;
    end else begin
      cur_slot_o  = (slot_q == '1) ? slot_q : slot_q + SLOT_W'(1);
      cur_right_o = right_q;
    end
  end

  assign frame_start_o = (cur_slot_o == '0) && !cur_right_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q    <= '0;
      right_q   <= 1'b0;
      started_q <= 1'b0;
    end else if (!act_i) begin
      slot_q    <= '0;
      right_q   <= 1'b0;
      started_q <= 1'b0;
    end else if (tick_i) begin
      started_q <= 1'b1;
      if (!master_i) begin
        slot_q  <= cur_slot_o;
        right_q <= cur_right_o;
      end else if (slot_q == half_i - SLOT_W'(1)) begin
        slot_q  <= '0;
        right_q <= !right_q;
      end else begin
        slot_q  <= slot_q + SLOT_W'(1);
      end
    end
  end

endmodule

// File: rtl/i2s_tx_shifter.sv
module i2s_tx_shifter
  import i2s_tx_pkg::*;
#(
  parameter int unsigned SMP_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic              tick_i,
  input  logic              frame_start_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              right_i,
  input  logic [BITS_W-1:0] bits_i,
  input  logic [SLOT_W-1:0] half_i,
  input  logic              rjust_i,
  input  logic              dly_i,
  input  logic              valid_i,
  input  logic [SMP_W-1:0]  left_i,
  input  logic [SMP_W-1:0]  right_word_i,
  input  logic              clr_i,
  output logic              ready_o,
  output logic              sd_o,
  output logic              lr_raw_o,
  output logic              underrun_o
);

  localparam int unsigned POS_W = SLOT_W + 1;

  logic [SMP_W-1:0] hold_l_q, hold_r_q;
  logic [SMP_W-1:0] new_l, new_r, word;
  logic             prev_q;
  logic             take, miss;

  assign ready_o = tick_i && frame_start_i;
  assign take    = ready_o && valid_i;
  assign miss    = ready_o && !valid_i;
  assign new_l   = valid_i ? left_i : '0;
  assign new_r   = valid_i ? right_word_i : '0;

  always_comb begin
    if (right_i)            word = frame_start_i ? new_r : hold_r_q;
    else if (frame_start_i) word = new_l;
    else                    word = hold_l_q;
  end

  // slot -> sample bit position
  logic [POS_W-1:0] pos, s_ext, h_ext, w_ext;
  logic             in_word, cur_bit;
  logic [SMP_W-1:0] shifted;

  always_comb begin
    s_ext = POS_W'(slot_i);
    h_ext = POS_W'(half_i);
    w_ext = POS_W'(bits_i);
    if (rjust_i) begin
      pos     = h_ext - POS_W'(1) - s_ext;
      in_word = (s_ext < h_ext) && (pos < w_ext);
    end else begin
      pos     = w_ext - POS_W'(1) - s_ext;
      in_word = (s_ext < w_ext);
    end
    shifted = word >> pos;
    cur_bit = in_word && shifted[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_l_q <= '0;
      hold_r_q <= '0;
    end else if (ready_o) begin
      hold_l_q <= new_l;
      hold_r_q <= new_r;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sd_o     <= 1'b0;
      prev_q   <= 1'b0;
      lr_raw_o <= 1'b0;
    end else if (!act_i) begin
      sd_o     <= 1'b0;
      prev_q   <= 1'b0;
      lr_raw_o <= 1'b0;
    end else if (tick_i) begin
      sd_o     <= dly_i ? prev_q : cur_bit;
      prev_q   <= cur_bit;
      lr_raw_o <= right_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    underrun_o <= 1'b0;
    else if (miss)  underrun_o <= 1'b1;
    else if (clr_i) underrun_o <= 1'b0;
  end

  logic unused_take;
  assign unused_take = take;

endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer
  import i2s_tx_pkg::*;
#(
  parameter int unsigned SMP_W       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             glb_en_i,
  input  logic             ch_en_i,
  input  logic [1:0]       cfg_wlen_i,
  input  logic             cfg_rjust_i,
  input  logic             cfg_dly_i,
  input  logic             cfg_lr_pol_i,
  input  logic             cfg_bck_pol_i,
  input  logic             cfg_master_i,
  input  logic             cfg_free_bck_i,
  input  logic             cfg_mdiv_i,
  input  logic [1:0]       cfg_fdiv_i,
  input  logic             smp_valid_i,
  output logic             smp_ready_o,
  input  logic [SMP_W-1:0] smp_left_i,
  input  logic [SMP_W-1:0] smp_right_i,
  input  logic             ext_bck_i,
  input  logic             ext_lrck_i,
  output logic             bck_o,
  output logic             lrck_o,
  output logic             sd_o,
  output logic             underrun_o,
  input  logic             underrun_clr_i
);

  tx_cfg_t cfg_q;
  logic    active;

  assign active = glb_en_i && ch_en_i;

  // settings frozen while running
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (!active) cfg_q <= '{wlen: cfg_wlen_i, rjust: cfg_rjust_i, dly: cfg_dly_i,
                                 lr_pol: cfg_lr_pol_i, bck_pol: cfg_bck_pol_i,
                                 master: cfg_master_i, free_bck: cfg_free_bck_i,
                                 mdiv: cfg_mdiv_i, fdiv: cfg_fdiv_i};
  end

  logic mst_q, free_q, bpol_q, lpol_q;
  assign mst_q  = cfg_q.master;
  assign free_q = cfg_q.free_bck;
  assign bpol_q = cfg_q.bck_pol;
  assign lpol_q = cfg_q.lr_pol;

  logic [SLOT_W-1:0] half;
  logic [BITS_W-1:0] bits;
  logic [PH_W-1:0]   ratio;

  assign half  = half_slots(cfg_q.fdiv);
  assign bits  = word_bits(cfg_q.wlen);
  assign ratio = slot_cycles(cfg_q.mdiv);

  logic tick_m, bck_raw, launch_s, ext_right, tick;

  i2s_tx_mclk_div u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (mst_q && (active || free_q)),
    .act_i     (mst_q && active),
    .ratio_i   (ratio),
    .tick_o    (tick_m),
    .bck_raw_o (bck_raw)
  );

  i2s_tx_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bck_i     (ext_bck_i),
    .lrck_i    (ext_lrck_i),
    .bck_pol_i (bpol_q),
    .lr_pol_i  (lpol_q),
    .launch_o  (launch_s),
    .right_o   (ext_right)
  );

  assign tick = mst_q ? tick_m : (launch_s && active);

  logic [SLOT_W-1:0] cur_slot;
  logic              cur_right, frame_start;

  i2s_tx_slot_ctr u_slot (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .act_i         (active),
    .tick_i        (tick),
    .master_i      (mst_q),
    .half_i        (half),
    .ext_right_i   (ext_right),
    .cur_slot_o    (cur_slot),
    .cur_right_o   (cur_right),
    .frame_start_o (frame_start)
  );

  logic lr_raw;

  i2s_tx_shifter #(.SMP_W(SMP_W)) u_shift (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .act_i         (active),
    .tick_i        (tick),
    .frame_start_i (frame_start),
    .slot_i        (cur_slot),
    .right_i       (cur_right),
    .bits_i        (bits),
    .half_i        (half),
    .rjust_i       (cfg_q.rjust),
    .dly_i         (cfg_q.dly),
    .valid_i       (smp_valid_i),
    .left_i        (smp_left_i),
    .right_word_i  (smp_right_i),
    .clr_i         (underrun_clr_i),
    .ready_o       (smp_ready_o),
    .sd_o          (sd_o),
    .lr_raw_o      (lr_raw),
    .underrun_o    (underrun_o)
  );

  assign bck_o  = mst_q && (bck_raw ^ bpol_q);
  assign lrck_o = mst_q && (lr_raw ^ lpol_q);

endmodule

// File: rtl/i2s_tx_serializer_chk.sv
module i2s_tx_serializer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic glb_en_i,
  input logic ch_en_i,
  input logic smp_valid_i,
  input logic smp_ready_o,
  input logic underrun_o,
  input logic underrun_clr_i,
  input logic bck_o,
  input logic lrck_o,
  input logic sd_o,
  input logic mst_q,
  input logic free_q,
  input logic bpol_q
);

  logic act;
  assign act = glb_en_i && ch_en_i;

  a_r9_ready_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_ready_o |-> act);

  a_r9_sd_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!act) |-> !sd_o);

  a_r11_ready_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_ready_o |=> !smp_ready_o);

  a_r12_underrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_o && !underrun_clr_i) |=> underrun_o);

  a_r12_underrun_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(underrun_o) |-> $past(smp_ready_o && !smp_valid_i));

  a_r12_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_clr_i && !(smp_ready_o && !smp_valid_i)) |=> !underrun_o);

  a_r8_slave_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mst_q |-> (!bck_o && !lrck_o));

  a_r10_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!act && !free_q && mst_q) && $past(!act && !free_q && mst_q, 2) &&
     mst_q && (bpol_q == $past(bpol_q))) |-> $stable(bck_o));

endmodule

bind i2s_tx_serializer i2s_tx_serializer_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .glb_en_i       (glb_en_i),
  .ch_en_i        (ch_en_i),
  .smp_valid_i    (smp_valid_i),
  .smp_ready_o    (smp_ready_o),
  .underrun_o     (underrun_o),
  .underrun_clr_i (underrun_clr_i),
  .bck_o          (bck_o),
  .lrck_o         (lrck_o),
  .sd_o           (sd_o),
  .mst_q          (mst_q),
  .free_q         (free_q),
  .bpol_q         (bpol_q)
);

// File: tb/i2s_tx_serializer_test.sv
module i2s_tx_serializer_test;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic glb_en = 0, ch_en = 0, valid = 0, clr = 0;
  logic [1:0] wlen = 0, fdiv = 0;
  logic rjust = 0, dly = 0, lpol = 0, bpol = 0, master = 1, free_bck = 0, mdiv = 0;
  logic [31:0] left = 0, right = 0;
  logic ext_bck = 1, ext_lr = 0;
  logic ready, bck, lrck, sd, urun;

  i2s_tx_serializer uut (
    .clk_i(clk), .rst_ni(rst_n), .glb_en_i(glb_en), .ch_en_i(ch_en),
    .cfg_wlen_i(wlen), .cfg_rjust_i(rjust), .cfg_dly_i(dly), .cfg_lr_pol_i(lpol),
    .cfg_bck_pol_i(bpol), .cfg_master_i(master), .cfg_free_bck_i(free_bck),
    .cfg_mdiv_i(mdiv), .cfg_fdiv_i(fdiv), .smp_valid_i(valid), .smp_ready_o(ready),
    .smp_left_i(left), .smp_right_i(right), .ext_bck_i(ext_bck), .ext_lrck_i(ext_lr),
    .bck_o(bck), .lrck_o(lrck), .sd_o(sd), .underrun_o(urun), .underrun_clr_i(clr)
  );

  int n_run = 0, n_fail = 0, cyc = 0;
  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // capture at each sampling edge of the bit clock
  bit cap_on = 0;
  int cap_n = 0;
  logic mon_pol = 0, prev_raw = 1;
  logic cap_sd [512];
  logic cap_lr [512];
  int   cap_t  [512];
  always @(negedge clk) begin
    logic b, raw;
    b   = master ? bck : ext_bck;
    raw = b ^ mon_pol;
    if (cap_on && !prev_raw && raw && cap_n < 512) begin
      cap_sd[cap_n] = sd;
      cap_lr[cap_n] = master ? lrck : ext_lr;
      cap_t[cap_n]  = cyc;
      cap_n++;
    end
    prev_raw = raw;
  end

  logic exp_sd [512];
  logic exp_lr [512];

  function automatic logic mbit(input logic [31:0] w, input int s, input int nb, input int h, input bit rj);
    int p;
    p = rj ? h - 1 - s : nb - 1 - s;
    if (p < 0 || p >= nb) return 1'b0;
    return w[p];
  endfunction

  task automatic build_exp(input int n, input int nb, input bit rj, input bit dl, input bit lp,
                           input logic [31:0] l0, r0, l1, r1);
    logic u, pv;
    pv = 1'b0;
    for (int g = 0; g < 2 * n; g++) begin
      int sl, s;
      bit hh;
      logic [31:0] w;
      sl = g % n;
      hh = (sl >= n / 2);
      s  = hh ? sl - n / 2 : sl;
      w  = (g < n) ? (hh ? r0 : l0) : (hh ? r1 : l1);
      u  = mbit(w, s, nb, n / 2, rj);
      exp_sd[g] = dl ? pv : u;
      pv = u;
      exp_lr[g] = hh ^ lp;
    end
  endtask

  task automatic cmp_stream(input int n, input string tag_sd, input string tag_lr);
    int bad_sd, bad_lr, first_sd, first_lr;
    bad_sd = 0; bad_lr = 0; first_sd = -1; first_lr = -1;
    for (int g = 0; g < 2 * n; g++) begin
      if (cap_sd[g] !== exp_sd[g]) begin bad_sd++; if (first_sd < 0) first_sd = g; end
      if (cap_lr[g] !== exp_lr[g]) begin bad_lr++; if (first_lr < 0) first_lr = g; end
    end
    check(bad_sd == 0, tag_sd, bad_sd, 0);
    if (first_sd >= 0) $display("  first sd mismatch at slot %0d", first_sd);
    check(bad_lr == 0, tag_lr, bad_lr, 0);
    if (first_lr >= 0) $display("  first lrck mismatch at slot %0d", first_lr);
  endtask

  task automatic wait_ready_take;
    while (!ready) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  typedef struct packed {
    logic [1:0] wl; logic rj; logic dl; logic lp; logic bp; logic md; logic [1:0] fd;
    logic [31:0] l0; logic [31:0] r0; logic [31:0] l1; logic [31:0] r1;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 32'h0000A5C3, 32'h00003C5A, 32'h00008001, 32'h00007FFE},
    '{2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd1, 32'h009ABCDE, 32'h00F0F00F, 32'h00800001, 32'h00123457},
    '{2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 32'hDEADBEEF, 32'h80000001, 32'h13579BDF, 32'hF00FF00F},
    '{2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0000C003, 32'h00005AA5, 32'h00000001, 32'h00008000},
    '{2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 32'h00FF1234, 32'h00A5C3E1, 32'h007E8001, 32'h00018181},
    '{2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 32'hCAFE1234, 32'h8001FFFF, 32'h0F0F5555, 32'h7FFF0000}
  };

  task automatic run_vec(input vec_t v, input int idx);
    int n, nb, p;
    n  = (v.fd == 2'd0) ? 32 : (v.fd == 2'd1) ? 64 : 128;
    nb = (v.wl == 2'd0) ? 16 : (v.wl == 2'd1) ? 24 : 32;
    p  = v.md ? 4 : 2;
    glb_en = 0; ch_en = 0;
    master = 1; free_bck = 0;
    wlen = v.wl; rjust = v.rj; dly = v.dl; lpol = v.lp; bpol = v.bp; mdiv = v.md; fdiv = v.fd;
    mon_pol = v.bp;
    repeat (4) @(negedge clk);
    cap_n = 0; cap_on = 1;
    left = v.l0; right = v.r0; valid = 1;
    glb_en = 1; ch_en = 1;
    #1;
    wait_ready_take();
    left = v.l1; right = v.r1;
    wait_ready_take();
    valid = 0;
    while (cap_n < 2 * n + 1) @(negedge clk);
    build_exp(n, nb, v.rj, v.dl, v.lp, v.l0, v.r0, v.l1, v.r1);
    cmp_stream(n, $sformatf("R1/R2/R3/R4 data vec %0d", idx), $sformatf("R5 lrck vec %0d", idx));
    // R7 slot timing
    check(cap_t[2 * n - 1] - cap_t[0] == (2 * n - 1) * p, $sformatf("R7 slot rate vec %0d", idx),
          cap_t[2 * n - 1] - cap_t[0], (2 * n - 1) * p);
    // R12: third frame had no pair
    check(urun === 1'b1, $sformatf("R12 underrun after vec %0d", idx), urun, 1);
    glb_en = 0;
    cap_on = 0;
    repeat (4) @(negedge clk);
    // R6 idle level
    check(bck === ~v.bp, $sformatf("R6 idle bck vec %0d", idx), bck, ~v.bp);
    clr = 1; @(negedge clk); clr = 0;
  endtask

  task automatic slave_gen(input int frames);
    for (int g = 0; g < frames * 32; g++) begin
      @(posedge clk); #1;
      ext_bck = 0;
      ext_lr  = ((g % 32) >= 16);
      repeat (6) @(posedge clk);
      #1;
      ext_bck = 1;
      repeat (5) @(posedge clk);
    end
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  initial begin
    int tog;
    logic b0, l0v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // reset state
    check(bck === 1'b1, "R6 reset bck idle", bck, 1);
    check(lrck === 1'b0, "R5 reset lrck", lrck, 0);
    check(sd === 1'b0, "R9 reset sd", sd, 0);
    check(ready === 1'b0, "R11 reset ready", ready, 0);
    check(urun === 1'b0, "R12 reset underrun", urun, 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R9 / R10: one enable only, gated clock
    master = 1; free_bck = 0; bpol = 0; lpol = 0; mdiv = 0; fdiv = 0; valid = 1;
    repeat (3) @(negedge clk);
    glb_en = 1; ch_en = 0;
    tog = 0; b0 = bck;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (ready) tog = tog + 100;
      if (sd) tog = tog + 1000;
      if (bck !== b0) tog++;
    end
    check(tog == 0, "R9 half enable does nothing", tog, 0);
    check(tog == 0, "R10 gated bck stopped", tog, 0);
    glb_en = 0; free_bck = 1;
    repeat (3) @(negedge clk);
    tog = 0; b0 = bck; l0v = lrck;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (bck !== b0) tog++;
      b0 = bck;
      if (lrck !== l0v) tog = tog + 1000;
    end
    check(tog == 20, "R10 free bck toggles, lrck still", tog, 20);
    free_bck = 0; valid = 0;
    repeat (3) @(negedge clk);

    // R12 set beats clear; R13 changes while running ignored
    wlen = 0; rjust = 0; dly = 0; lpol = 0; bpol = 0; mdiv = 0; fdiv = 0; mon_pol = 0;
    left = 32'h0000B00C; right = 32'h00006DB6;
    repeat (3) @(negedge clk);
    cap_n = 0; cap_on = 1;
    glb_en = 1; ch_en = 1;
    #1;
    while (!ready) @(negedge clk);
    clr = 1;
    @(posedge clk); #1;
    clr = 0;
    check(urun === 1'b1, "R12 underrun wins over clear", urun, 1);
    valid = 1; lpol = 1; rjust = 1; dly = 1; wlen = 2;
    while (cap_n < 64) @(negedge clk);
    build_exp(32, 16, 0, 0, 0, 32'h0, 32'h0, 32'h0000B00C, 32'h00006DB6);
    cmp_stream(32, "R12/R13 silent frame then data", "R13 lrck polarity held");
    check(urun === 1'b1, "R12 flag sticky", urun, 1);
    @(negedge clk);
    clr = 1; @(negedge clk); clr = 0;
    @(negedge clk);
    check(urun === 1'b0, "R12 clear alone", urun, 0);
    glb_en = 0; cap_on = 0; valid = 0;
    repeat (4) @(negedge clk);

    // R8 slave mode
    master = 0; wlen = 0; rjust = 0; dly = 1; lpol = 0; bpol = 0; fdiv = 0; mon_pol = 0;
    ext_bck = 1; ext_lr = 0;
    repeat (4) @(negedge clk);
    cap_n = 0; cap_on = 1;
    left = 32'h00009C31; right = 32'h0000E007; valid = 1;
    glb_en = 1; ch_en = 1;
    fork
      slave_gen(3);
      begin
        #1;
        wait_ready_take();
        left = 32'h00000FF0; right = 32'h0000A001;
        wait_ready_take();
        valid = 0;
      end
    join
    build_exp(32, 16, 0, 1, 0, 32'h00009C31, 32'h0000E007, 32'h00000FF0, 32'h0000A001);
    cmp_stream(32, "R8 slave data", "R8 slave frame clock");
    check({bck, lrck} === 2'b00, "R8 slave outputs low", {bck, lrck}, 0);
    glb_en = 0; cap_on = 0;
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule